// File: doc/BRIEF.md
# Tuner Control Serial Interface

This block is a two-wire serial (I2C) target that loads the control word of a three-band TV tuner and reports the tuner's status. It receives a divider word for the local oscillator, four port bits, a charge-pump current select, a reference divider ratio, an AGC take-over point and an AGC time constant. None of these settings reaches the outputs while the transaction is still running. Each data byte goes into a shadow copy. On the STOP condition the whole shadow copy moves to the live outputs in a single clock.

A read transaction returns two bytes. The first is a status byte with the PLL lock flag and the AGC-active flag. The second is the ADC code. Two strap pins select one of four target addresses. The port bits also drive the enables for the mixers and oscillators. When neither the low-band bit nor the mid-band bit is set, the high band is enabled.

The bus pads are outside this block. `scl_i` and `sda_i` are the pad inputs, and `sda_oe_o` pulls the SDA line low. The lock flag, the AGC flag and the ADC code arrive as inputs from analog circuits outside the block.

Top module: `tuner_ctl`

## Requirements
- R1: The target address is `{5'b11000, addr_sel_i}`, with the R/W bit as bit 0 of the address byte (1 = read). The target acknowledges a matching address byte by pulling SDA low during the ninth clock.
- R2: The target does not acknowledge an address byte that does not match. A write sent to a foreign address changes no output.
- R3: After a write address, data bytes are taken in this order: byte 0 sets `div_o[14:8]` from bits 6:0; byte 1 sets `div_o[7:0]`; byte 2 sets `cp_hi_o` from bit 0 and the reference code from bits 2:1; byte 3 sets `port_o` from bits 3:0; byte 4 sets the AGC take-over code from bits 2:0; byte 5 sets `agc_slow_o` from bit 0. Each data byte is acknowledged. Bytes after the sixth are acknowledged and discarded.
- R4: Written values reach the outputs only on a STOP condition. Between STOPs the live outputs do not change.
- R5: The AGC take-over code has five legal values, 0 to 4. Codes 5, 6 and 7 are stored as 4.
- R6: Reference codes 0, 1 and 2 select the 64, 80 and 128 ratios. Code 3 is stored as 2.
- R7: Enable decode from the port bits: `lo_mix_en_o = lo_osc_en_o = port[0]`; `mid_osc_en_o = port[1] & ~port[0]`; `mh_mix_en_o = ~port[0]`; `hi_osc_en_o = ~port[0] & ~port[1]`. `port_o[3:2]` drive nothing else.
- R8: In a read, the first byte is `{lock_i, agc_act_i, 6'b0}`, the second is the ADC code zero-extended to 8 bits, and every later byte is 0x00. The inputs are captured when the address is acknowledged. A NACK from the controller ends the read.
- R9: After reset, every stored field is 0. This gives `hi_osc_en_o = 1` and `mh_mix_en_o = 1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, which oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock from the pad |
| sda_i | input | 1 | Bus data from the pad |
| sda_oe_o | output | 1 | Pulls SDA low when high |
| addr_sel_i | input | 2 | Address strap |
| lock_i | input | 1 | PLL lock flag |
| agc_act_i | input | 1 | AGC active flag |
| adc_i | input | 3 | ADC code |
| div_o | output | 15 | Oscillator divider word |
| port_o | output | 4 | Port outputs |
| cp_hi_o | output | 1 | High charge-pump current |
| ref_sel_o | output | 2 | Reference ratio code |
| agc_top_o | output | 3 | AGC take-over point |
| agc_slow_o | output | 1 | Slow AGC time constant |
| lo_mix_en_o | output | 1 | Low-band mixer enable |
| mh_mix_en_o | output | 1 | Mid/high-band mixer enable |
| lo_osc_en_o | output | 1 | Low-band oscillator enable |
| mid_osc_en_o | output | 1 | Mid-band oscillator enable |
| hi_osc_en_o | output | 1 | High-band oscillator enable |

## Verification
A wrong byte index would put data into the wrong field. A missed STOP would leave the shadow copy unapplied. In both cases the live outputs differ from the bench's model a few clocks after the STOP, and the bench compares the outputs on every clock. A shadow copy that leaks early would change an output in the middle of a transaction, and the same per-clock comparison catches it at that cycle. Errors in the bit counter or the state machine first appear as a missing or misplaced acknowledge on the ninth clock, or as read data that is shifted by one bit.

// File: rtl/tuner_pkg.sv
package tuner_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ACK_A, S_WR, S_ACK_W, S_RD, S_MACK
  } bus_st_e;

  typedef struct packed {
    logic [14:0] div;
    logic [3:0]  port;
    logic        cp_hi;
    logic [1:0]  ref_sel;
    logic [2:0]  agc_top;
    logic        agc_slow;
  } tuner_cfg_t;

  localparam int unsigned NUM_WR_BYTES = 6;
  localparam logic [2:0]  AGC_TOP_MAX  = 3'd4;
endpackage

// File: rtl/i2c_tgt_core.sv
module i2c_tgt_core #(
  parameter logic [4:0] ADDR_BASE = 5'b11000,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [1:0]       addr_sel_i,
  input  logic [7:0]       stat_i,
  input  logic [7:0]       adc_byte_i,
  output logic             sda_oe_o,
  output logic             wr_stb_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic             stop_o
);
  import tuner_pkg::*;

  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  bus_st_e          st_q;
  logic [2:0]       scl_q, sda_q;
  logic [3:0]       cnt_q;
  logic [7:0]       sh_q, tx_q, adc_q;
  logic             rw_q;
  logic [1:0]       rd_idx_q;
  logic [IDX_W-1:0] idx_q;
  logic             scl_r, scl_f, start_d, stop_d;

  assign scl_r   = scl_q[1] & ~scl_q[2];
  assign scl_f   = ~scl_q[1] & scl_q[2];
  assign start_d = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_d  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      adc_q     <= '0;
      rw_q      <= 1'b0;
      rd_idx_q  <= '0;
      idx_q     <= '0;
      wr_stb_o  <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
      stop_o    <= 1'b0;
    end else begin
      wr_stb_o <= 1'b0;
      stop_o   <= stop_d;
      if (start_d) begin
        st_q  <= S_ADDR;
        cnt_q <= '0;
        idx_q <= '0;
      end else if (stop_d) begin
        st_q <= S_IDLE;
      end else begin
        unique case (st_q)
          S_ADDR, S_WR: begin
            if (scl_r) begin
              sh_q  <= {sh_q[6:0], sda_q[1]};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_f && cnt_q == 4'd8) begin
              cnt_q <= '0;
              if (st_q == S_ADDR) begin
                if (sh_q[7:1] == {ADDR_BASE, addr_sel_i}) begin
                  st_q <= S_ACK_A;
                  rw_q <= sh_q[0];
                end else begin
                  st_q <= S_IDLE;
                end
              end else begin
                st_q      <= S_ACK_W;
                wr_stb_o  <= 1'b1;
                wr_idx_o  <= idx_q;
                wr_data_o <= sh_q;
                if (idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
              end
            end
          end
          S_ACK_A: if (scl_f) begin
            if (rw_q) begin
              st_q     <= S_RD;
              tx_q     <= stat_i;
              adc_q    <= adc_byte_i;
              rd_idx_q <= 2'd1;
            end else begin
              st_q <= S_WR;
            end
          end
          S_ACK_W: if (scl_f) st_q <= S_WR;
          S_RD: if (scl_f) begin
            if (cnt_q == 4'd7) begin
              st_q  <= S_MACK;
              cnt_q <= '0;
            end else begin
              tx_q  <= {tx_q[6:0], 1'b0};
              cnt_q <= cnt_q + 4'd1;
            end
          end
          S_MACK: begin
            if (scl_r && sda_q[1]) begin
              st_q <= S_IDLE;
            end else if (scl_f) begin
              st_q     <= S_RD;
              tx_q     <= (rd_idx_q == 2'd1) ? adc_q : 8'h00;
              rd_idx_q <= 2'd2;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = (st_q == S_ACK_A) || (st_q == S_ACK_W) || (st_q == S_RD && !tx_q[7]);

  // R3
  wr_stb_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> st_q == S_ACK_W);
  // R1
  ack_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q == S_ACK_A) |-> $past(st_q == S_ADDR));
endmodule

// File: rtl/tuner_regs.sv
module tuner_regs #(
  parameter int unsigned IDX_W = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_stb_i,
  input  logic [IDX_W-1:0]        wr_idx_i,
  input  logic [7:0]              wr_data_i,
  input  logic                    stop_i,
  output tuner_pkg::tuner_cfg_t   cfg_o
);
  import tuner_pkg::*;

  tuner_cfg_t shd_q, live_q;
  logic [2:0] top_clamped;
  logic [1:0] ref_clamped;

  assign top_clamped = (wr_data_i[2:0] > AGC_TOP_MAX) ? AGC_TOP_MAX : wr_data_i[2:0];
  assign ref_clamped = (wr_data_i[2:1] == 2'd3) ? 2'd2 : wr_data_i[2:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q  <= '0;
      live_q <= '0;
    end else begin
      if (wr_stb_i) begin
        unique case (wr_idx_i)
          3'd0: shd_q.div[14:8] <= wr_data_i[6:0];
          3'd1: shd_q.div[7:0]  <= wr_data_i;
          3'd2: begin
            shd_q.cp_hi   <= wr_data_i[0];
            shd_q.ref_sel <= ref_clamped;
          end
          3'd3: shd_q.port     <= wr_data_i[3:0];
          3'd4: shd_q.agc_top  <= top_clamped;
          3'd5: shd_q.agc_slow <= wr_data_i[0];
          default: ;
        endcase
      end
      if (stop_i) live_q <= shd_q;
    end
  end

  assign cfg_o = live_q;

  // R4
  live_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(stop_i) |-> $stable(live_q));
  // R5
  agc_top_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q.agc_top <= AGC_TOP_MAX);
  // R6
  ref_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q.ref_sel != 2'd3);
endmodule

// File: rtl/band_dec.sv
module band_dec (
  input  logic [1:0] band_bits_i,
  output logic       lo_mix_en_o,
  output logic       mh_mix_en_o,
  output logic       lo_osc_en_o,
  output logic       mid_osc_en_o,
  output logic       hi_osc_en_o
);
  // low band has priority; no band bit means high band
  assign lo_mix_en_o  = band_bits_i[0];
  assign lo_osc_en_o  = band_bits_i[0];
  assign mh_mix_en_o  = ~band_bits_i[0];
  assign mid_osc_en_o = band_bits_i[1] & ~band_bits_i[0];
  assign hi_osc_en_o  = ~band_bits_i[1] & ~band_bits_i[0];

  // R7
  always_comb begin
    osc_onehot_chk: assert ($onehot({lo_osc_en_o, mid_osc_en_o, hi_osc_en_o}));
    mix_onehot_chk: assert (lo_mix_en_o != mh_mix_en_o);
  end
endmodule

// File: rtl/tuner_ctl.sv
module tuner_ctl #(
  parameter logic [4:0]  ADDR_BASE = 5'b11000,
  parameter int unsigned ADC_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [1:0]       addr_sel_i,
  input  logic             lock_i,
  input  logic             agc_act_i,
  input  logic [ADC_W-1:0] adc_i,
  output logic [14:0]      div_o,
  output logic [3:0]       port_o,
  output logic             cp_hi_o,
  output logic [1:0]       ref_sel_o,
  output logic [2:0]       agc_top_o,
  output logic             agc_slow_o,
  output logic             lo_mix_en_o,
  output logic             mh_mix_en_o,
  output logic             lo_osc_en_o,
  output logic             mid_osc_en_o,
  output logic             hi_osc_en_o
);
  import tuner_pkg::*;

  localparam int unsigned IDX_W = $clog2(NUM_WR_BYTES + 2);

  logic             wr_stb, stop;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data, stat_byte, adc_byte;
  tuner_cfg_t       cfg;

  assign stat_byte = {lock_i, agc_act_i, 6'b0};
  assign adc_byte  = {{(8-ADC_W){1'b0}}, adc_i};

  i2c_tgt_core #(.ADDR_BASE(ADDR_BASE), .IDX_W(IDX_W)) u_core (
    .clk_i, .rst_ni, .scl_i, .sda_i, .addr_sel_i,
    .stat_i(stat_byte), .adc_byte_i(adc_byte), .sda_oe_o,
    .wr_stb_o(wr_stb), .wr_idx_o(wr_idx), .wr_data_o(wr_data), .stop_o(stop)
  );

  tuner_regs #(.IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni, .wr_stb_i(wr_stb), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .stop_i(stop), .cfg_o(cfg)
  );

  band_dec u_band (
    .band_bits_i(cfg.port[1:0]),
    .lo_mix_en_o, .mh_mix_en_o, .lo_osc_en_o, .mid_osc_en_o, .hi_osc_en_o
  );

  assign div_o      = cfg.div;
  assign port_o     = cfg.port;
  assign cp_hi_o    = cfg.cp_hi;
  assign ref_sel_o  = cfg.ref_sel;
  assign agc_top_o  = cfg.agc_top;
  assign agc_slow_o = cfg.agc_slow;
endmodule

// File: tb/tb_tuner_ctl.sv
`timescale 1ns/1ps
module tb_tuner_ctl;
  localparam int PH = 10;

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic sda_oe;
  logic [1:0] sel = 0;
  logic lock = 0, agc_act = 0;
  logic [2:0] adc = 0;
  logic [14:0] div;
  logic [3:0] port;
  logic cp_hi, agc_slow, lo_mix, mh_mix, lo_osc, mid_osc, hi_osc;
  logic [1:0] ref_sel;
  logic [2:0] agc_top;
  wire sda_line = sda_m & ~sda_oe;

  int total = 0, bad = 0;
  bit cmp_en = 0;
  int e_div = 0, e_port = 0, e_cp = 0, e_ref = 0, e_top = 0, e_slow = 0;
  int s_div = 0, s_port = 0, s_cp = 0, s_ref = 0, s_top = 0, s_slow = 0;

  always #2.5 clk = ~clk;

  tuner_ctl dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_sel_i(sel), .lock_i(lock), .agc_act_i(agc_act), .adc_i(adc),
    .div_o(div), .port_o(port), .cp_hi_o(cp_hi), .ref_sel_o(ref_sel),
    .agc_top_o(agc_top), .agc_slow_o(agc_slow), .lo_mix_en_o(lo_mix),
    .mh_mix_en_o(mh_mix), .lo_osc_en_o(lo_osc), .mid_osc_en_o(mid_osc),
    .hi_osc_en_o(hi_osc)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // R4 R7 R9: per-clock model comparison
  always @(negedge clk) if (cmp_en) begin
    chk("R4 div", div, e_div);
    chk("R4 port", port, e_port);
    chk("R4 cp", cp_hi, e_cp);
    chk("R6 ref", ref_sel, e_ref);
    chk("R5 top", agc_top, e_top);
    chk("R4 slow", agc_slow, e_slow);
    chk("R7 lo", {lo_mix, lo_osc}, (e_port & 1) ? 3 : 0);
    chk("R7 mh_mix", mh_mix, (e_port & 1) ? 0 : 1);
    chk("R7 mid_osc", mid_osc, ((e_port & 3) == 2) ? 1 : 0);
    chk("R7 hi_osc", hi_osc, ((e_port & 3) == 0) ? 1 : 0);
  end

  task automatic wt(input int n); repeat (n) @(posedge clk); endtask

  task automatic i2c_start;
    sda_m = 1; scl_m = 1; wt(PH); sda_m = 0; wt(PH); scl_m = 0; wt(PH);
  endtask

  task automatic i2c_stop;
    sda_m = 0; wt(PH); scl_m = 1; wt(PH);
    cmp_en = 0;
    sda_m = 1; wt(PH);
    e_div = s_div; e_port = s_port; e_cp = s_cp;
    e_ref = s_ref; e_top = s_top; e_slow = s_slow;
    cmp_en = 1; wt(PH);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(PH); scl_m = 1; wt(PH); scl_m = 0; wt(PH);
    end
    sda_m = 1; wt(PH); scl_m = 1; wt(PH / 2); ack = !sda_line; wt(PH / 2);
    scl_m = 0; wt(PH);
  endtask

  task automatic rbyte(input bit nack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wt(PH); scl_m = 1; wt(PH / 2); b[i] = sda_line; wt(PH / 2); scl_m = 0;
    end
    wt(2); sda_m = nack; wt(PH); scl_m = 1; wt(PH); scl_m = 0; wt(2); sda_m = 1; wt(PH);
  endtask

  function automatic void model_byte(int idx, logic [7:0] d);
    case (idx)
      0: s_div = (s_div & 'hFF) | ((d & 'h7F) << 8);
      1: s_div = (s_div & 'h7F00) | d;
      2: begin s_cp = d & 1; s_ref = (d >> 1) & 3; if (s_ref == 3) s_ref = 2; end
      3: s_port = d & 'hF;
      4: begin s_top = d & 7; if (s_top > 4) s_top = 4; end
      5: s_slow = d & 1;
      default: ;
    endcase
  endfunction

  task automatic write_seq(input logic [6:0] a, input logic [7:0] d[], input bit exp_ack);
    bit ack;
    i2c_start;
    wbyte({a, 1'b0}, ack);
    chk(exp_ack ? "R1 addr ack" : "R2 addr nack", ack, exp_ack);
    if (ack) begin
      foreach (d[i]) begin
        wbyte(d[i], ack);
        chk("R3 data ack", ack, 1);
        model_byte(i, d[i]);
      end
    end else begin
      foreach (d[i]) wbyte(d[i], ack);
    end
    // R4: outputs must still equal old values here (per-clock compare running)
    i2c_stop;
  endtask

  initial begin
    int fin;
    fin = 0;
    fork
      begin : wd
        wt(190000);
        chk("watchdog", 0, 1);
        fin = 1;
      end
      begin : main
        logic [7:0] rb;
        bit ack;
        wt(4); rst_n = 1; wt(4);
        // R9 reset state
        chk("R9 div", div, 0);
        chk("R9 hi_osc", hi_osc, 1);
        chk("R9 mh_mix", mh_mix, 1);
        chk("R9 sda", sda_oe, 0);
        cmp_en = 1;

        // R1 R3 R7: full write, low band
        write_seq(7'h60, '{8'h12, 8'h34, 8'h03, 8'h0D, 8'h02, 8'h01}, 1);
        // R7 mid band, R5 clamp 5, R6 clamp ref 3
        write_seq(7'h60, '{8'hFF, 8'hA5, 8'h06, 8'h02, 8'h05, 8'h00}, 1);
        // R7 both set -> low priority; R5 clamp 7
        write_seq(7'h60, '{8'h00, 8'h01, 8'h04, 8'h07, 8'h07, 8'h01}, 1);
        // R9-style high default; R5 code 6; extra byte discarded (R3)
        write_seq(7'h60, '{8'h55, 8'h66, 8'h01, 8'h0C, 8'h06, 8'h00, 8'hFF}, 1);
        // R5 legal code 4 kept; partial write keeps other shadow fields
        write_seq(7'h60, '{8'h0A, 8'h0B, 8'h02, 8'h01, 8'h04}, 1);
        // R2 wrong address ignored
        write_seq(7'h61, '{8'h7F, 8'hFF, 8'h07, 8'h0F, 8'h03, 8'h01}, 0);
        // R1 other straps
        sel = 2'd3;
        write_seq(7'h63, '{8'h21, 8'h43}, 1);
        write_seq(7'h60, '{8'h11}, 0);
        sel = 2'd2;
        write_seq(7'h62, '{8'h01, 8'h02, 8'h00, 8'h00}, 1);

        // R8 read
        lock = 1; agc_act = 0; adc = 3'd5;
        i2c_start; wbyte({7'h62, 1'b1}, ack);
        chk("R8 rd addr ack", ack, 1);
        lock = 0; adc = 3'd2;
        rbyte(0, rb); chk("R8 status", rb, 8'h80);
        rbyte(0, rb); chk("R8 adc", rb, 8'h05);
        rbyte(1, rb); chk("R8 pad", rb, 8'h00);
        i2c_stop;
        agc_act = 1; adc = 3'd7;
        i2c_start; wbyte({7'h62, 1'b1}, ack);
        rbyte(0, rb); chk("R8 status agc", rb, 8'h40);
        rbyte(1, rb); chk("R8 adc 7", rb, 8'h07);
        i2c_stop;
        // R2 read to wrong address: line stays released
        i2c_start; wbyte({7'h60, 1'b1}, ack);
        chk("R2 rd nack", ack, 0);
        rbyte(1, rb); chk("R2 released", rb, 8'hFF);
        i2c_stop;
        wt(20);
        fin = 1;
      end
    join_any
    disable fork;
    cmp_en = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule